// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block maps a 30-bit system address onto one of eight programmable chip-select windows and decides which device path serves the access. Each window is placed by a 6-bit base that is aligned to 16 MB. A 4-bit mask sets how many of the address bits just above that 16 MB boundary take part in the compare, so a window spans 16, 32, 64, 128 or 256 MB. Address bits outside the compare make the device appear again at every window-size step. The offset passed to the device keeps only the bits that are not compared.

A second word for each chip-select gives the device kind. A separate prefetch word can bind the prefetch engine to one chip-select. While that binding is active, a NAND-class window is sent to the FIFO port and not to the direct NAND register port. The decode runs combinationally from the address. The configuration registers change only on a clock edge that carries a write.

The block has no data stream. The access address is a plain control input, and no valid/ready handshake is applied to it. The select outputs follow the address in the same cycle, so no back-pressure is involved. The configuration port is a single-cycle write strobe and never stalls.

Top module: `cswin_decoder`

## Requirements
- R1: After reset, chip-select 0 is valid with base 0 and mask 0xF, so addresses 0x0000000 to 0x0FFFFFF select it as NOR. Every other chip-select is invalid and every mask error bit is 0.
- R2: A window word holds the base in bits 5:0, the valid flag in bit 6 and the mask in bits 11:8. A valid window with mask 0xF matches exactly the 16 MB that starts at base << 24.
- R3: Address bit 24+j is compared with base bit j only where mask bit j is 1. Address bits 29:28 are always compared with base bits 5:4. `win_off` is address bits 27:0 with the compared bits 27:24 cleared, and it is 0 when nothing matches.
- R4: A window whose valid flag is 0 never matches, whatever its base and mask are.
- R5: When several valid windows match, only the lowest-numbered one appears in `cs_sel`, which is one-hot or zero.
- R6: When no window matches, `miss` is 1, `cs_sel` is 0 and `tgt` is 0 (none).
- R7: The target code is 1 (NOR) when device-word bits 11:10 of the winning chip-select are 0. Any other value of those bits gives 2 (NAND).
- R8: When prefetch-word bit 7 is 1 and prefetch-word bits 26:24 equal the winning chip-select, a NAND-class window gives target 3 (FIFO). A NOR window is not affected by the prefetch word.
- R9: `mask_err[i]` is 1 when window i is valid and its mask is not 0x8, 0xC, 0xE or 0xF. A mask of 0 is also legal while `allow_full` is 1. The window still decodes with the mask it holds.
- R10: A write takes effect on the clock edge where `wr_en` is 1. `wr_addr` 0..7 selects the window word of a chip-select, 8..15 selects its device word, and 16..31 selects the prefetch word. When `wr_en` is 0, the value of `wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allow_full | input | 1 | Permits mask 0 (256 MB window) |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration word select |
| wr_data | input | 32 | Configuration write data |
| acc_addr | input | 30 | System access address |
| cs_sel | output | 8 | One-hot winning chip-select |
| tgt | output | 2 | Target: 0 none, 1 NOR, 2 NAND, 3 FIFO |
| miss | output | 1 | No valid window matches |
| win_off | output | 28 | Offset within the selected window |
| mask_err | output | 8 | Illegal mask on a valid window, per chip-select |

## Verification
The decode is probed with four kinds of input: addresses just inside and just outside a 16 MB window, addresses in wider windows whose uncompared bits vary, addresses covered by two overlapping windows, and addresses after a window has been invalidated. Together these separate an off-by-one in the compared bits, a wrong offset mask, a wrong priority order and a missing valid gate. The same address is then replayed while the device word and the prefetch binding change. This exposes target routing that ignores the chip-select number or the device kind. Masks 0x3 and 0, tried with `allow_full` low and then high, show whether the legality check and the 256 MB case are handled.

// File: rtl/cswin_pkg.sv
package cswin_pkg;
  localparam int BASE_W = 6;
  localparam int MASK_W = 4;
  localparam int DEV_W  = 2;

  // Bit positions inside the configuration words
  localparam int VALID_BIT  = 6;
  localparam int MASK_LSB   = 8;
  localparam int DEV_LSB    = 10;
  localparam int PF_EN_BIT  = 7;
  localparam int PF_CS_LSB  = 24;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_NOR  = 2'd1,
    TGT_NAND = 2'd2,
    TGT_FIFO = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              valid;
    logic [BASE_W-1:0] base;
  } win_t;

  function automatic logic mask_legal(input logic [MASK_W-1:0] m, input logic full_ok);
    return (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF) ||
           (full_ok && (m == 4'h0));
  endfunction
endpackage

// File: rtl/cswin_regs.sv
module cswin_regs
  import cswin_pkg::*;
#(
  parameter int N_CS  = 8,
  parameter int SEL_W = $clog2(N_CS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W+1:0]              wr_addr,
  input  logic [31:0]                   wr_data,
  output win_t [N_CS-1:0]               win_o,
  output logic [N_CS-1:0][DEV_W-1:0]    dev_o,
  output logic                          pf_en_o,
  output logic [SEL_W-1:0]              pf_cs_o
);
  logic [1:0] space;
  assign space = wr_addr[SEL_W+1:SEL_W];

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:27], wr_data[23:12]};

  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    logic hit_idx;
    assign hit_idx = wr_en && (wr_addr[SEL_W-1:0] == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_o[i] <= '{mask: 4'hF, valid: (i == 0), base: '0};
      end else if (hit_idx && space == 2'b00) begin
        win_o[i] <= '{mask:  wr_data[MASK_LSB +: MASK_W],
                      valid: wr_data[VALID_BIT],
                      base:  wr_data[BASE_W-1:0]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dev_o[i] <= '0;
      end else if (hit_idx && space == 2'b01) begin
        dev_o[i] <= wr_data[DEV_LSB +: DEV_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_en_o <= 1'b0;
      pf_cs_o <= '0;
    end else if (wr_en && space[1]) begin
      pf_en_o <= wr_data[PF_EN_BIT];
      pf_cs_o <= wr_data[PF_CS_LSB +: SEL_W];
    end
  end
endmodule

// File: rtl/cswin_match.sv
module cswin_match
  import cswin_pkg::*;
#(
  parameter int AW       = 30,
  parameter int PAGE_LSB = AW - BASE_W,
  parameter int OFF_W    = PAGE_LSB + MASK_W
) (
  input  win_t             win,
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  logic [MASK_W-1:0] field;
  logic              top_eq;
  logic              field_eq;

  assign field    = addr[PAGE_LSB +: MASK_W];
  assign top_eq   = addr[AW-1:OFF_W] == win.base[BASE_W-1:MASK_W];
  assign field_eq = ((field ^ win.base[MASK_W-1:0]) & win.mask) == '0;
  assign hit      = win.valid && top_eq && field_eq;
  // Uncompared field bits stay in the offset, which gives the wrap.
  assign off      = {field & ~win.mask, addr[PAGE_LSB-1:0]};
endmodule

// File: rtl/cswin_pick.sv
module cswin_pick
  import cswin_pkg::*;
#(
  parameter int N_CS  = 8,
  parameter int OFF_W = 28,
  parameter int SEL_W = $clog2(N_CS)
) (
  input  logic [N_CS-1:0]             hit,
  input  logic [N_CS-1:0][OFF_W-1:0]  off,
  input  logic [N_CS-1:0][DEV_W-1:0]  dev,
  input  logic                        pf_en,
  input  logic [SEL_W-1:0]            pf_cs,
  output logic [N_CS-1:0]             sel,
  output tgt_e                        tgt,
  output logic                        miss,
  output logic [OFF_W-1:0]            off_o
);
  logic [SEL_W-1:0] idx;
  logic             found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        idx   = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    sel   = '0;
    off_o = '0;
    tgt   = TGT_NONE;
    if (found) begin
      sel[idx] = 1'b1;
      off_o    = off[idx];
      if (dev[idx] == '0)                tgt = TGT_NOR;
      else if (pf_en && (pf_cs == idx))  tgt = TGT_FIFO;
      else                               tgt = TGT_NAND;
    end
  end

  assign miss = !found;
endmodule

// File: rtl/cswin_decoder.sv
module cswin_decoder
  import cswin_pkg::*;
#(
  parameter int N_CS = 8,
  parameter int AW   = 30,
  localparam int SEL_W    = $clog2(N_CS),
  localparam int PAGE_LSB = AW - BASE_W,
  localparam int OFF_W    = PAGE_LSB + MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_full,
  input  logic              wr_en,
  input  logic [SEL_W+1:0]  wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [AW-1:0]     acc_addr,
  output logic [N_CS-1:0]   cs_sel,
  output logic [1:0]        tgt,
  output logic              miss,
  output logic [OFF_W-1:0]  win_off,
  output logic [N_CS-1:0]   mask_err
);
  win_t [N_CS-1:0]            win;
  logic [N_CS-1:0][DEV_W-1:0] dev;
  logic                       pf_en_q;
  logic [SEL_W-1:0]           pf_cs_q;
  logic [N_CS-1:0]            hit;
  logic [N_CS-1:0][OFF_W-1:0] off;
  tgt_e                       tgt_w;

  cswin_regs #(.N_CS(N_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_o(win), .dev_o(dev), .pf_en_o(pf_en_q), .pf_cs_o(pf_cs_q)
  );

  for (genvar i = 0; i < N_CS; i++) begin : g_win
    cswin_match #(.AW(AW)) u_match (
      .win(win[i]), .addr(acc_addr), .hit(hit[i]), .off(off[i])
    );
    assign mask_err[i] = win[i].valid && !mask_legal(win[i].mask, allow_full);
  end

  cswin_pick #(.N_CS(N_CS), .OFF_W(OFF_W)) u_pick (
    .hit(hit), .off(off), .dev(dev), .pf_en(pf_en_q), .pf_cs(pf_cs_q),
    .sel(cs_sel), .tgt(tgt_w), .miss(miss), .off_o(win_off)
  );

  assign tgt = tgt_w;
endmodule

// File: rtl/cswin_decoder_chk.sv
module cswin_decoder_chk #(
  parameter int N_CS  = 8,
  parameter int SEL_W = $clog2(N_CS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W+1:0] wr_addr,
  input logic             wr_valid_bit,
  input logic [N_CS-1:0]  cs_sel,
  input logic [1:0]       tgt,
  input logic             miss,
  input logic             pf_en,
  input logic [SEL_W-1:0] pf_cs
);
  // R5: at most one chip-select is driven
  assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  // R6: a miss drives neither select nor target
  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs_sel == '0 && tgt == 2'd0));

  // R7: a NAND target needs a hit
  assert_nand_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == 2'd2) |-> (!miss && cs_sel != '0));

  // R8: the FIFO target only for the bound chip-select with the engine on
  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == 2'd3) |-> (pf_en && cs_sel[pf_cs]));

  // R4: invalidating a window removes it from the selects at the next cycle
  assert_invalid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[SEL_W+1:SEL_W] == 2'b00 && !wr_valid_bit)
      |=> (cs_sel[$past(wr_addr[SEL_W-1:0])] == 1'b0));
endmodule

bind cswin_decoder cswin_decoder_chk #(.N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_valid_bit(wr_data[6]), .cs_sel(cs_sel), .tgt(tgt), .miss(miss),
  .pf_en(pf_en_q), .pf_cs(pf_cs_q)
);

// File: tb/sim_cswin_decoder.sv
`timescale 1ns/100ps
module sim_cswin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        allow_full = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [29:0] acc_addr = '0;
  logic [7:0]  cs_sel;
  logic [1:0]  tgt;
  logic        miss;
  logic [27:0] win_off;
  logic [7:0]  mask_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cswin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .allow_full(allow_full), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .acc_addr(acc_addr),
    .cs_sel(cs_sel), .tgt(tgt), .miss(miss), .win_off(win_off), .mask_err(mask_err)
  );

  // Requirement-level model of the configuration
  logic [3:0] m_mask [8];
  logic       m_valid[8];
  logic [5:0] m_base [8];
  logic [1:0] m_dev  [8];
  logic       m_pf_en;
  logic [2:0] m_pf_cs;

  typedef struct {
    logic [7:0]  sel;
    logic [1:0]  tgt;
    logic        miss;
    logic [27:0] off;
    logic [7:0]  err;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t e;

  function automatic exp_t model(input logic [29:0] a, input string tag);
    exp_t r;
    int   w;
    r.sel = '0; r.tgt = 2'd0; r.miss = 1'b1; r.off = '0; r.err = '0; r.tag = tag;
    w = -1;
    for (int i = 7; i >= 0; i--) begin
      logic ok;
      ok = m_valid[i] && (a[29:28] == m_base[i][5:4]);
      for (int j = 0; j < 4; j++)
        if (m_mask[i][j] && (a[24+j] != m_base[i][j])) ok = 1'b0;
      if (ok) w = i;
      if (m_valid[i] && !(m_mask[i] inside {4'h8, 4'hC, 4'hE, 4'hF} ||
                          (allow_full && m_mask[i] == 4'h0)))
        r.err[i] = 1'b1;
    end
    if (w >= 0) begin
      r.sel[w] = 1'b1;
      r.miss   = 1'b0;
      r.off    = {a[27:24] & ~m_mask[w], a[23:0]};
      if (m_dev[w] == 2'd0)                       r.tgt = 2'd1;
      else if (m_pf_en && m_pf_cs == 3'(w))        r.tgt = 2'd3;
      else                                         r.tgt = 2'd2;
    end
    return r;
  endfunction

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(posedge clk);
    if (ad[4]) begin
      m_pf_en = d[7]; m_pf_cs = d[26:24];
    end else if (ad[3]) begin
      m_dev[ad[2:0]] = d[11:10];
    end else begin
      m_mask[ad[2:0]] = d[11:8]; m_valid[ad[2:0]] = d[6]; m_base[ad[2:0]] = d[5:0];
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic probe(input logic [29:0] a, input string tag);
    @(posedge clk); #1;
    acc_addr = a;
    sbq.push_back(model(a, tag));
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      e = sbq.pop_front();
      checks++;
      if (cs_sel !== e.sel || tgt !== e.tgt || miss !== e.miss ||
          win_off !== e.off || mask_err !== e.err) begin
        errors++;
        $display("FAIL %s addr=%h: sel=%b tgt=%0d miss=%b off=%h err=%b expected sel=%b tgt=%0d miss=%b off=%h err=%b",
                 e.tag, acc_addr, cs_sel, tgt, miss, win_off, mask_err,
                 e.sel, e.tgt, e.miss, e.off, e.err);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_mask[i] = 4'hF; m_valid[i] = (i == 0); m_base[i] = '0; m_dev[i] = '0;
    end
    m_pf_en = 1'b0; m_pf_cs = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset windows
    probe(30'h0000000, "R1 low edge of cs0");
    probe(30'h0FFFFFF, "R1 top of cs0");
    probe(30'h1000000, "R1 R6 just above cs0");
    // R2: 16 MB window at base 2
    wr(5'd1, 32'h0000_0F42);
    probe(30'h2000010, "R2 inside cs1");
    probe(30'h1FFFFFF, "R2 below cs1");
    probe(30'h3000000, "R2 R6 above cs1");
    // R3: 64 MB window with wrap and offset
    wr(5'd2, 32'h0000_0C44);
    probe(30'h5ABCDEF, "R3 mask C offset");
    probe(30'h7000001, "R3 mask C top");
    probe(30'h8000000, "R3 R6 past mask C");
    // R5: overlapping cs3 with cs1
    wr(5'd3, 32'h0000_0F02);
    wr(5'd3, 32'h0000_0F42);
    probe(30'h2000100, "R5 lowest wins");
    // R4: invalidate cs1, cs3 takes over
    wr(5'd1, 32'h0000_0F02);
    probe(30'h2000100, "R4 invalid cs1 skipped");
    // R7: device kinds
    wr(5'd11, 32'h0000_0800);
    probe(30'h2000100, "R7 type 2 is NAND");
    wr(5'd11, 32'h0000_0400);
    probe(30'h2000100, "R7 type 1 is NAND");
    // R8: prefetch binding
    wr(5'd16, 32'h0300_0080);
    probe(30'h2000100, "R8 bound NAND to FIFO");
    wr(5'd16, 32'h0000_0080);
    probe(30'h0000040, "R8 NOR unaffected");
    wr(5'd16, 32'h0200_0080);
    probe(30'h2000100, "R8 other cs bound stays NAND");
    wr(5'd16, 32'h0300_0000);
    probe(30'h2000100, "R8 engine off stays NAND");
    // R9: mask legality
    wr(5'd4, 32'h0000_0350);
    probe(30'h10000000, "R9 mask 3 flagged");
    wr(5'd5, 32'h0000_0060);
    probe(30'h28000000, "R9 R3 mask 0 flagged");
    @(posedge clk); #1 allow_full = 1'b1;
    probe(30'h2FFFFFFF, "R9 mask 0 allowed");
    // R10: data without strobe is ignored
    @(posedge clk); #1;
    wr_addr = 5'd0; wr_data = 32'h0000_0000;
    @(posedge clk); #1;
    wr_addr = 5'd10; wr_data = 32'hFFFF_FFFF;
    probe(30'h0000200, "R10 no strobe no change");
    // R10: prefetch word reached through high address
    wr(5'd31, 32'h0300_0080);
    probe(30'h2000100, "R10 high prefetch address");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule